// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block counts hardware activity for software profiling. It holds one dedicated cycle counter and a parameter-chosen number of event counters, four by default. Each event counter tallies the cycles in which one of the event input lines is high. Software picks that line for each counter with an 8-bit type code. All counters are 32 bits wide. When a counter wraps it latches an overflow flag, and one shared interrupt line is raised while any flagged counter also has its interrupt enabled.

Software reaches the unit through a single-cycle register port with a write strobe, an address and write data. Reads are combinational and have no side effects. The event counters are not mapped one by one. A select register names one counter, and two indirect registers then reach that counter's value and type code. Enables and interrupt enables are changed through separate set and clear addresses, so no read-modify-write is needed. The cycle counter can be slowed to one step every 64 qualifying clocks. It can also be frozen while an external prohibit input is high.

Top module: `perf_mon_unit`

## Requirements
- R1: Register addresses: 0 control, 1 enable-set, 2 enable-clear, 3 irq-enable-set, 4 irq-enable-clear, 5 overflow flags, 6 select, 7 cycle count, 8 indirect event count, 9 indirect event type. Any other address reads 0.
- R2: The control register stores bit 0 (run), bit 3 (divide), bit 4 (export) and bit 5 (prohibit honour). Bits 1 and 2 always read 0. Bits 15:11 read the number of event counters. After reset every register and counter reads 0 and irq is low.
- R3: In the enable, irq-enable and flag masks, bit N is event counter N and bit 31 is the cycle counter. Writing 1 to a bit at a set address sets it, and writing 1 at the clear address clears it. Zero bits change nothing. Bits of counters that do not exist read 0, and either address reads the mask.
- R4: An event counter adds one at each clock edge where its type-code input is high. A type code at or beyond the number of event inputs never counts.
- R5: A counter moves only while the run bit and its own enable bit are both set. The cycle counter, when undivided, adds one per such clock.
- R6: Every counter wraps from all ones to 0, and the wrap sets its flag bit.
- R7: Writing 1 to a flag bit clears it. Writing 0 leaves it.
- R8: irq is high exactly while some counter has both its flag and its irq-enable bit set.
- R9: The 5-bit select value routes the indirect count and type accesses. When the value is at or above the number of counters, these accesses read 0 and writes do nothing.
- R10: Writing control bit 1 zeros all event counters. Writing control bit 2 zeros the cycle counter and its prescaler.
- R11: With the divide bit set, the cycle counter steps once per 64 qualifying clocks.
- R12: With the prohibit-honour bit set and dbg_prohibit high, the cycle counter holds.
- R13: A software write of a counter value wins over an increment in the same cycle.
- R14: export_en follows control bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| evt_in | input | NUM_EVT_IN | Event lines, one per type code |
| dbg_prohibit | input | 1 | Request to stop the cycle counter |
| export_en | output | 1 | Export enable from the control register |
| irq | output | 1 | Combined overflow interrupt |

## Verification
A corrupted count, mask or select register shows up at reg_rdata on the next read of its address. An indirect access that reaches the wrong counter shows up as a neighbour's value changing or leaking through. A missed wrap or a lost flag appears on irq in the cycle after the wrapping edge. A wrong prescaler phase is only visible after a full 64-clock period, so the divide test runs two periods and reads the exact step count.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
   localparam int ADDR_W  = 4;
   localparam int DATA_W  = 32;
   localparam int CYC_BIT = 31;

   typedef enum logic [ADDR_W-1:0] {
      A_CTRL   = 4'd0,
      A_EN_SET = 4'd1,
      A_EN_CLR = 4'd2,
      A_IE_SET = 4'd3,
      A_IE_CLR = 4'd4,
      A_OVF    = 4'd5,
      A_SEL    = 4'd6,
      A_CYC    = 4'd7,
      A_EVCNT  = 4'd8,
      A_EVTYPE = 4'd9
   } pmu_addr_e;

   // control bit positions (software visible)
   localparam int CB_RUN    = 0;
   localparam int CB_EVRST  = 1;
   localparam int CB_CYCRST = 2;
   localparam int CB_DIV    = 3;
   localparam int CB_EXPORT = 4;
   localparam int CB_PROHIB = 5;
   localparam int CB_NUM_LO = 11;
endpackage

// File: rtl/pmu_mask_reg.sv
module pmu_mask_reg #(
   parameter int          W    = 32,
   parameter logic [W-1:0] KEEP = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_we,
   input  logic         clr_we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] mask_q
);
   logic [W-1:0] set_v, clr_v;
   assign set_v = set_we ? wdata : '0;
   assign clr_v = clr_we ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q <= '0;
      else        mask_q <= ((mask_q | set_v) & ~clr_v) & KEEP;
   end
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         inc,
   output logic [W-1:0] count_q,
   output logic         wrap
);
   // clear beats software load, which beats counting
   assign wrap = inc && !clr && !load && (&count_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    count_q <= '0;
      else if (clr)  count_q <= '0;
      else if (load) count_q <= load_val;
      else if (inc)  count_q <= count_q + 1'b1;
   end
endmodule

// File: rtl/pmu_prescaler.sv
module pmu_prescaler #(
   parameter int DIV = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic adv,
   output logic tick
);
   localparam int PW = $clog2(DIV);
   localparam logic [PW-1:0] LAST = PW'(DIV - 1);

   logic [PW-1:0] ph_q;
   assign tick = adv && (ph_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ph_q <= '0;
      else if (clr)  ph_q <= '0;
      else if (tick) ph_q <= '0;
      else if (adv)  ph_q <= ph_q + 1'b1;
   end
endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit #(
   parameter int NUM_CTR    = 4,
   parameter int NUM_EVT_IN = 16,
   parameter int CTR_W      = 32,
   parameter int CYC_DIV    = 64,
   parameter int TYPE_W     = 8,
   parameter int SEL_W      = 5
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_we,
   input  logic [3:0]            reg_addr,
   input  logic [31:0]           reg_wdata,
   output logic [31:0]           reg_rdata,
   input  logic [NUM_EVT_IN-1:0] evt_in,
   input  logic                  dbg_prohibit,
   output logic                  export_en,
   output logic                  irq
);
   import pmu_pkg::*;

   localparam logic [31:0] VALID_MASK = (32'h1 << CYC_BIT) | ((32'h1 << NUM_CTR) - 32'h1);
   localparam logic [31:0] NUM_FIELD  = 32'(NUM_CTR) << CB_NUM_LO;

   // elaboration-time parameter checks
   if (NUM_CTR < 1 || NUM_CTR > 31) begin : g_bad_num
      $error("NUM_CTR must lie in 1..31");
   end
   if (CTR_W < 2 || CTR_W > 32) begin : g_bad_w
      $error("CTR_W must lie in 2..32");
   end
   if (CYC_DIV < 2) begin : g_bad_div
      $error("CYC_DIV must be at least 2");
   end
   if (TYPE_W < 1 || TYPE_W > 8 || SEL_W != 5) begin : g_bad_fields
      $error("TYPE_W must lie in 1..8 and SEL_W must be 5");
   end
   if (NUM_EVT_IN < 1 || NUM_EVT_IN > (1 << TYPE_W)) begin : g_bad_ev
      $error("NUM_EVT_IN must fit the type code");
   end

   // ---------------- write decode ----------------
   logic wr_ctrl, wr_sel, wr_cyc, wr_evcnt, wr_evtype, wr_ovf;
   assign wr_ctrl   = reg_we && (reg_addr == A_CTRL);
   assign wr_sel    = reg_we && (reg_addr == A_SEL);
   assign wr_cyc    = reg_we && (reg_addr == A_CYC);
   assign wr_evcnt  = reg_we && (reg_addr == A_EVCNT);
   assign wr_evtype = reg_we && (reg_addr == A_EVTYPE);
   assign wr_ovf    = reg_we && (reg_addr == A_OVF);

   // ---------------- control ----------------
   logic ctrl_e, ctrl_d, ctrl_x, ctrl_dp;
   logic ev_rst, cyc_rst;
   assign ev_rst  = wr_ctrl && reg_wdata[CB_EVRST];
   assign cyc_rst = wr_ctrl && reg_wdata[CB_CYCRST];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_e <= 1'b0; ctrl_d <= 1'b0; ctrl_x <= 1'b0; ctrl_dp <= 1'b0;
      end else if (wr_ctrl) begin
         ctrl_e  <= reg_wdata[CB_RUN];
         ctrl_d  <= reg_wdata[CB_DIV];
         ctrl_x  <= reg_wdata[CB_EXPORT];
         ctrl_dp <= reg_wdata[CB_PROHIB];
      end
   end
   assign export_en = ctrl_x;

   logic [SEL_W-1:0] sel_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sel_q <= '0;
      else if (wr_sel) sel_q <= reg_wdata[SEL_W-1:0];
   end

   // ---------------- masks ----------------
   logic [31:0] en_q, ie_q;
   pmu_mask_reg #(.W(32), .KEEP(VALID_MASK)) u_en (
      .clk(clk), .rst_n(rst_n),
      .set_we(reg_we && reg_addr == A_EN_SET),
      .clr_we(reg_we && reg_addr == A_EN_CLR),
      .wdata(reg_wdata), .mask_q(en_q));
   pmu_mask_reg #(.W(32), .KEEP(VALID_MASK)) u_ie (
      .clk(clk), .rst_n(rst_n),
      .set_we(reg_we && reg_addr == A_IE_SET),
      .clr_we(reg_we && reg_addr == A_IE_CLR),
      .wdata(reg_wdata), .mask_q(ie_q));

   // ---------------- cycle counter ----------------
   logic cyc_run, cyc_tick, cyc_inc, cyc_wrap;
   logic [CTR_W-1:0] cyc_q;
   assign cyc_run = ctrl_e && en_q[CYC_BIT] && !(ctrl_dp && dbg_prohibit);

   pmu_prescaler #(.DIV(CYC_DIV)) u_pre (
      .clk(clk), .rst_n(rst_n), .clr(cyc_rst),
      .adv(cyc_run && ctrl_d), .tick(cyc_tick));
   assign cyc_inc = ctrl_d ? cyc_tick : cyc_run;

   pmu_counter #(.W(CTR_W)) u_cyc (
      .clk(clk), .rst_n(rst_n), .clr(cyc_rst), .load(wr_cyc),
      .load_val(reg_wdata[CTR_W-1:0]), .inc(cyc_inc),
      .count_q(cyc_q), .wrap(cyc_wrap));

   // ---------------- event counters ----------------
   logic [CTR_W-1:0]  ev_cnt  [NUM_CTR];
   logic [TYPE_W-1:0] ev_type [NUM_CTR];
   logic [NUM_CTR-1:0] ev_wrap;

   for (genvar i = 0; i < NUM_CTR; i++) begin : g_ev
      logic sel_me, hit;
      assign sel_me = (sel_q == SEL_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                   ev_type[i] <= '0;
         else if (wr_evtype && sel_me) ev_type[i] <= reg_wdata[TYPE_W-1:0];
      end

      always_comb begin
         hit = 1'b0;
         for (int j = 0; j < NUM_EVT_IN; j++)
            if (ev_type[i] == TYPE_W'(j)) hit = evt_in[j];
      end

      pmu_counter #(.W(CTR_W)) u_ctr (
         .clk(clk), .rst_n(rst_n), .clr(ev_rst), .load(wr_evcnt && sel_me),
         .load_val(reg_wdata[CTR_W-1:0]), .inc(ctrl_e && en_q[i] && hit),
         .count_q(ev_cnt[i]), .wrap(ev_wrap[i]));
   end

   // ---------------- overflow flags / interrupt ----------------
   logic [31:0] ovf_q, ovf_set, ovf_clr;
   always_comb begin
      ovf_set = '0;
      ovf_set[NUM_CTR-1:0] = ev_wrap;
      ovf_set[CYC_BIT]     = cyc_wrap;
   end
   assign ovf_clr = wr_ovf ? reg_wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ovf_q <= '0;
      else        ovf_q <= ((ovf_q & ~ovf_clr) | ovf_set) & VALID_MASK;
   end
   assign irq = |(ovf_q & ie_q);

   // ---------------- read mux ----------------
   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_CTRL:   reg_rdata = NUM_FIELD | {26'd0, ctrl_dp, ctrl_x, ctrl_d, 2'b00, ctrl_e};
         A_EN_SET,
         A_EN_CLR: reg_rdata = en_q;
         A_IE_SET,
         A_IE_CLR: reg_rdata = ie_q;
         A_OVF:    reg_rdata = ovf_q;
         A_SEL:    reg_rdata = 32'(sel_q);
         A_CYC:    reg_rdata = 32'(cyc_q);
         A_EVCNT: begin
            for (int i = 0; i < NUM_CTR; i++)
               if (sel_q == SEL_W'(i)) reg_rdata = 32'(ev_cnt[i]);
         end
         A_EVTYPE: begin
            for (int i = 0; i < NUM_CTR; i++)
               if (sel_q == SEL_W'(i)) reg_rdata = 32'(ev_type[i]);
         end
         default:  reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/pmu_checker.sv
module pmu_checker #(
   parameter int NUM_CTR = 4,
   parameter int CTR_W   = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_we,
   input logic [3:0]       reg_addr,
   input logic [31:0]      reg_wdata,
   input logic [31:0]      reg_rdata,
   input logic             irq,
   input logic             ctrl_e,
   input logic [31:0]      en_q,
   input logic [31:0]      ovf_q,
   input logic [CTR_W-1:0] cyc_q,
   input logic [CTR_W-1:0] ev0_q,
   input logic [4:0]       sel_q
);
   import pmu_pkg::*;
   localparam logic [31:0] VM = (32'h1 << CYC_BIT) | ((32'h1 << NUM_CTR) - 32'h1);

   p_ctrl_ro_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == A_CTRL) |-> (reg_rdata[15:11] == 5'(NUM_CTR) && reg_rdata[2:1] == 2'b00));

   p_en_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == A_EN_SET) |=>
         ((en_q & $past(reg_wdata) & VM) == ($past(reg_wdata) & VM)));

   p_en_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == A_EN_CLR) |=> ((en_q & $past(reg_wdata)) == 32'd0));

   p_cyc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_e && !reg_we) |=> $stable(cyc_q));

   p_wrap_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_we && ev0_q == '1 && ctrl_e && en_q[0]) |=> (ev0_q == '0) -> ovf_q[0]);

   p_irq_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ovf_q != 32'd0));

   p_oob_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((32'(sel_q) >= NUM_CTR) && (reg_addr == A_EVCNT || reg_addr == A_EVTYPE))
         |-> (reg_rdata == 32'd0));
endmodule

bind perf_mon_unit pmu_checker #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
   .ctrl_e(ctrl_e), .en_q(en_q), .ovf_q(ovf_q), .cyc_q(cyc_q),
   .ev0_q(ev_cnt[0]), .sel_q(sel_q));

// File: tb/perf_mon_unit_tb_top.sv
module perf_mon_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [15:0] evt_in = '0;
   logic        dbg_prohibit = 1'b0;
   logic        export_en, irq;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   perf_mon_unit dut_i (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in),
      .dbg_prohibit(dbg_prohibit), .export_en(export_en), .irq(irq));

   localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_IDLE = 2'd2, K_IRQ = 2'd3;

   function automatic logic [57:0] mk(logic [1:0] k, logic [3:0] rq, logic [3:0] a,
                                      logic [31:0] d, logic [15:0] e);
      return {k, rq, a, d, e};
   endfunction

   localparam int NV = 60;
   localparam logic [57:0] VEC [NV] = '{
      mk(K_RD,   2, 0, 32'h2000, 0),        // R2 count field
      mk(K_WR,   0, 1, 32'hFFFF_FFFF, 0),
      mk(K_RD,   3, 1, 32'h8000_000F, 0),   // R3 absent bits read 0
      mk(K_WR,   0, 2, 32'h2, 0),
      mk(K_RD,   3, 2, 32'h8000_000D, 0),   // R3 clear
      mk(K_WR,   0, 1, 32'h2, 0),
      mk(K_WR,   0, 6, 32'h1, 0),
      mk(K_WR,   0, 9, 32'h3, 0),
      mk(K_WR,   0, 6, 32'h0, 0),
      mk(K_WR,   0, 9, 32'h2, 0),
      mk(K_RD,   9, 9, 32'h2, 0),           // R9 indirect type
      mk(K_WR,   0, 0, 32'h1, 0),
      mk(K_IDLE, 0, 0, 0, 16'h0004),
      mk(K_IDLE, 0, 0, 0, 16'h0004),
      mk(K_IDLE, 0, 0, 0, 16'h0004),
      mk(K_IDLE, 0, 0, 0, 16'h000C),
      mk(K_IDLE, 0, 0, 0, 16'h000C),
      mk(K_RD,   4, 8, 32'd5, 0),           // R4 counter 0
      mk(K_WR,   0, 6, 32'h1, 0),
      mk(K_RD,   4, 8, 32'd2, 0),           // R4 counter 1
      mk(K_WR,   0, 0, 32'h0, 0),
      mk(K_IDLE, 0, 0, 0, 16'h000C),
      mk(K_IDLE, 0, 0, 0, 16'h000C),
      mk(K_RD,   5, 8, 32'd2, 0),           // R5 run bit off
      mk(K_WR,   0, 6, 32'h5, 0),
      mk(K_RD,   9, 8, 32'd0, 0),           // R9 out of range read
      mk(K_WR,   0, 8, 32'h1234, 0),
      mk(K_WR,   0, 6, 32'h1, 0),
      mk(K_RD,   9, 8, 32'd2, 0),           // R9 write ignored, no alias
      mk(K_WR,   0, 6, 32'h0, 0),
      mk(K_WR,   0, 8, 32'hFFFF_FFFE, 0),
      mk(K_WR,   0, 3, 32'h1, 0),
      mk(K_WR,   0, 0, 32'h1, 0),
      mk(K_IDLE, 0, 0, 0, 16'h0004),
      mk(K_IDLE, 0, 0, 0, 16'h0004),
      mk(K_WR,   0, 0, 32'h0, 0),
      mk(K_RD,   6, 5, 32'h1, 0),           // R6 flag
      mk(K_RD,   6, 8, 32'h0, 0),           // R6 wrapped value
      mk(K_IRQ,  8, 0, 32'h1, 0),           // R8
      mk(K_WR,   0, 5, 32'h0, 0),
      mk(K_RD,   7, 5, 32'h1, 0),           // R7 zero keeps
      mk(K_WR,   0, 5, 32'h1, 0),
      mk(K_RD,   7, 5, 32'h0, 0),           // R7 one clears
      mk(K_IRQ,  8, 0, 32'h0, 0),           // R8
      mk(K_WR,   0, 0, 32'h2, 0),
      mk(K_WR,   0, 6, 32'h1, 0),
      mk(K_RD,  10, 8, 32'h0, 0),           // R10 event reset
      mk(K_RD,  10, 0, 32'h2000, 0),        // R10 pulse bits read 0
      mk(K_RD,   1, 15, 32'h0, 0),          // R1 unmapped
      mk(K_WR,   0, 2, 32'h2, 0),
      mk(K_WR,   0, 0, 32'h1, 0),
      mk(K_IDLE, 0, 0, 0, 16'h0008),
      mk(K_WR,   0, 0, 32'h0, 0),
      mk(K_RD,   5, 8, 32'h0, 0),           // R5 own enable off
      mk(K_WR,   0, 1, 32'h2, 0),
      mk(K_WR,   0, 9, 32'h40, 0),
      mk(K_WR,   0, 0, 32'h1, 0),
      mk(K_IDLE, 0, 0, 0, 16'hFFFF),
      mk(K_WR,   0, 0, 32'h0, 0),
      mk(K_RD,   4, 8, 32'h0, 0)            // R4 type beyond inputs
   };

   task automatic check(bit ok, string tag, logic [31:0] got, logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic wr(logic [3:0] a, logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk);
   endtask

   task automatic rd(logic [3:0] a, logic [31:0] exp, string tag);
      @(negedge clk);
      reg_we = 1'b0; reg_addr = a;
      #1 check(reg_rdata == exp, tag, reg_rdata, exp);
      @(posedge clk);
   endtask

   task automatic idle(int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         reg_we = 1'b0;
         @(posedge clk);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_run++; n_fail++;
         $display("FAIL watchdog got=hung exp=done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // reset state, R2
      rd(4'd1, 32'h0, "R2 reset enable");
      rd(4'd3, 32'h0, "R2 reset irq enable");
      rd(4'd5, 32'h0, "R2 reset flags");
      rd(4'd7, 32'h0, "R2 reset cycle");
      #1 check(irq == 1'b0, "R2 reset irq", 32'(irq), 0);

      for (int v = 0; v < NV; v++) begin
         @(negedge clk);
         evt_in    = VEC[v][15:0];
         reg_addr  = VEC[v][51:48];
         reg_wdata = VEC[v][47:16];
         reg_we    = (VEC[v][57:56] == K_WR);
         #1;
         if (VEC[v][57:56] == K_RD) begin
            n_run++;
            if (reg_rdata != VEC[v][47:16]) begin
               n_fail++;
               $display("FAIL R%0d step %0d got=%h exp=%h", VEC[v][55:52], v, reg_rdata, VEC[v][47:16]);
            end
         end else if (VEC[v][57:56] == K_IRQ) begin
            n_run++;
            if (irq != VEC[v][16]) begin
               n_fail++;
               $display("FAIL R%0d step %0d irq got=%b exp=%b", VEC[v][55:52], v, irq, VEC[v][16]);
            end
         end
         @(posedge clk);
      end
      @(negedge clk) evt_in = '0;

      // R5 cycle counter, undivided
      wr(4'd0, 32'h4); wr(4'd0, 32'h1); idle(10); wr(4'd0, 32'h0);
      rd(4'd7, 32'd11, "R5 cycle count");
      // R10 cycle reset
      wr(4'd7, 32'h55); rd(4'd7, 32'h55, "R13 cycle load");
      wr(4'd0, 32'h4); rd(4'd7, 32'h0, "R10 cycle reset");
      // R11 divide by 64
      wr(4'd0, 32'h9); idle(127); wr(4'd0, 32'h8);
      rd(4'd7, 32'd2, "R11 divided count");
      // R12 prohibit
      wr(4'd0, 32'h4);
      @(negedge clk) dbg_prohibit = 1'b1;
      wr(4'd0, 32'h21); idle(5); wr(4'd0, 32'h0);
      rd(4'd7, 32'd0, "R12 held");
      wr(4'd0, 32'h1); wr(4'd0, 32'h0);
      rd(4'd7, 32'd1, "R12 not honoured");
      @(negedge clk) dbg_prohibit = 1'b0;
      // R14 export
      wr(4'd0, 32'h10);
      #1 check(export_en == 1'b1, "R14 export on", 32'(export_en), 1);
      wr(4'd0, 32'h0);
      #1 check(export_en == 1'b0, "R14 export off", 32'(export_en), 0);
      // R13 load beats increment
      wr(4'd6, 32'h0); wr(4'd1, 32'h1); wr(4'd0, 32'h1);
      @(negedge clk) evt_in = 16'h0004;
      reg_we = 1'b1; reg_addr = 4'd8; reg_wdata = 32'h100;
      @(posedge clk);
      @(negedge clk) evt_in = '0;
      wr(4'd0, 32'h0);
      rd(4'd8, 32'h100, "R13 load priority");
      // R6/R8 cycle counter wrap
      wr(4'd5, 32'hFFFF_FFFF); wr(4'd4, 32'hFFFF_FFFF); wr(4'd3, 32'h8000_0000);
      wr(4'd7, 32'hFFFF_FFFF); wr(4'd0, 32'h1); wr(4'd0, 32'h0);
      rd(4'd5, 32'h8000_0000, "R6 cycle wrap flag");
      #1 check(irq == 1'b1, "R8 irq on cycle wrap", 32'(irq), 1);
      wr(4'd4, 32'h8000_0000);
      #1 check(irq == 1'b0, "R8 irq masked", 32'(irq), 0);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule